// File: doc/BRIEF.md
# Two-Bank SDRAM Command Legality Monitor

This block watches the registered command pins of a two-bank single-data-rate SDRAM. It decodes each command and flags the ones issued in a state where the memory would not accept them. For each bank it keeps three facts: whether a row is open, whether a read or write burst with auto precharge is still running, and whether that bank is still recovering from the precharge that closes such a burst. It also tracks the short settling window that follows a mode register write.

The result is a registered error code and a violation flag. Both are valid for the single cycle after the offending command. The monitor only observes the bus. A command it flags leaves its tracked state untouched, so a faulty sequence is reported once and not carried into later decisions. Burst length, precharge recovery time and the mode-register settling time are parameters: `BL` (default 4), `TRP` (default 2) and `TMRD` (default 2).

Top module: `sdr_cmd_guard`

## Requirements
- R1: A command is decoded only when `cs_n` is low and `cke` was high at the previous clock edge. Otherwise the cycle counts as a deselect, which never flags. After reset the previous-`cke` register is cleared, both banks are idle and `err_code` is 0.
- R2: The command is given by {`ras_n`,`cas_n`,`we_n`}: 000 mode write (`ba`=0 standard register, `ba`=1 extended register), 001 refresh (auto refresh when `cke` is high, self-refresh entry when `cke` is low), 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 NOP. For activate, read, write and precharge, `ba`=0 selects bank 0 and `ba`=1 selects bank 1.
- R3: A mode write while either bank is not idle gives code 2. A bank counts as idle when no row is open and no auto-precharge sequence is pending.
- R4: After an accepted mode write, any command other than NOP or deselect in the next `TMRD`-1 cycles gives code 1. With the default, that is only the cycle right after the mode write.
- R5: Auto refresh or self-refresh entry while either bank is not idle gives code 3.
- R6: A read or write to a bank with no open row gives code 5. An activate to a bank whose row is open gives code 6.
- R7: A read or write with `a10` high closes the bank's row and starts a burst of `BL` cycles. A read or write to either bank issued 1 to `BL`-1 cycles after it gives code 4. From `BL` cycles on, such commands are judged as normal.
- R8: An activate to a bank that ran an auto-precharge burst gives code 7 when issued fewer than `BL`+`TRP` cycles after the burst command. It is legal from `BL`+`TRP` cycles on.
- R9: A precharge with `a10` high closes both banks and ignores `ba`. With `a10` low it closes only the bank `ba` selects. Precharge always gives code 0 outside the mode-write window.
- R10: Burst stop gives code 0 at any time outside the mode-write window, including during an auto-precharge burst.
- R11: `err_code` is registered. It shows the code for the command sampled at one clock edge from that edge until the next edge. `viol` is high exactly when `err_code` is nonzero. A flagged command changes no tracked state.
- R12: When several rules fail, the lowest code wins among codes 1 to 5. For read and write, code 4 is checked before code 5. For activate, code 7 is checked before code 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Registered clock enable |
| cs_n | input | 1 | Registered chip select, active low |
| ras_n | input | 1 | Registered row strobe |
| cas_n | input | 1 | Registered column strobe |
| we_n | input | 1 | Registered write enable |
| ba | input | 1 | Bank address |
| a10 | input | 1 | Auto-precharge / all-banks address bit |
| viol | output | 1 | High for one cycle after an illegal command |
| err_code | output | 4 | Violation code for the previous command, 0 when legal |

## Verification
Every result is due one cycle after the stimulus. The command is sampled at a rising edge and its code is visible from that edge until the next one. The bench therefore drives each command on a falling edge and reads `err_code` and `viol` at the following falling edge, before the next command takes effect. The time windows are counted in cycles from the edge where the command was sampled. Auto-precharge commands are followed by probes at offsets 1, 3, `BL`, `BL`+1 and `BL`+`TRP`, and the mode write by probes at offsets 1 and 2. The bench places each probe at exactly that count of one-cycle commands.

// File: rtl/sdr_guard_pkg.sv
package sdr_guard_pkg;

  typedef enum logic [3:0] {
    C_DESEL, C_NOP, C_MRS, C_EMRS, C_AREF, C_SREF,
    C_ACT, C_RD, C_WR, C_PRE, C_BST
  } cmd_e;

  typedef enum logic [3:0] {
    E_NONE      = 4'd0,
    E_SETTLE    = 4'd1,
    E_MRS_BUSY  = 4'd2,
    E_REF_BUSY  = 4'd3,
    E_AP_LOCK   = 4'd4,
    E_NO_ROW    = 4'd5,
    E_ROW_OPEN  = 4'd6,
    E_ACT_EARLY = 4'd7
  } err_e;

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_guard_pkg::*;
(
  input  logic cke_prev_i,
  input  logic cke_i,
  input  logic cs_n_i,
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  input  logic ba_i,
  output cmd_e cmd_o
);

  always_comb begin
    cmd_o = C_DESEL;
    if (cke_prev_i && !cs_n_i) begin
      unique case ({ras_n_i, cas_n_i, we_n_i})
        3'b000: cmd_o = ba_i ? C_EMRS : C_MRS;
        3'b001: cmd_o = cke_i ? C_AREF : C_SREF;
        3'b010: cmd_o = C_PRE;
        3'b011: cmd_o = C_ACT;
        3'b100: cmd_o = C_WR;
        3'b101: cmd_o = C_RD;
        3'b110: cmd_o = C_BST;
        default: cmd_o = C_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdr_bank_track.sv
module sdr_bank_track #(
  parameter int BL  = 4,
  parameter int TRP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic rw_i,
  input  logic ap_i,
  input  logic pre_i,
  output logic open_o,
  output logic lock_o,
  output logic busy_o
);

  localparam int LOAD = BL + TRP - 1;
  localparam int CW   = $clog2(LOAD + 1);

  logic          open_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (act_i)
        open_q <= 1'b1;
      else if (pre_i || (rw_i && ap_i))
        open_q <= 1'b0;

      if (rw_i && ap_i)
        cnt_q <= CW'(LOAD);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign open_o = open_q;
  assign lock_o = cnt_q > CW'(TRP);
  assign busy_o = cnt_q != '0;

  // R6: an accepted activate leaves the row open
  p_act_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |=> open_q);

  // R7: an auto-precharge access closes the row and starts the window
  p_ap_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_i && ap_i) |=> (!open_q && lock_o));

  // R8: the recovery countdown only moves downward once started
  p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !(rw_i && ap_i)) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdr_cmd_guard.sv
module sdr_cmd_guard
  import sdr_guard_pkg::*;
#(
  parameter int BL   = 4,
  parameter int TRP  = 2,
  parameter int TMRD = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       ba,
  input  logic       a10,
  output logic       viol,
  output logic [3:0] err_code
);

  localparam int NBANK = 2;
  localparam int MW    = $clog2(TMRD + 1);

  logic          cke_q;
  logic [MW-1:0] mrs_cnt_q;
  cmd_e          cmd;
  err_e          err_next;
  logic [3:0]    err_q;
  logic          accept;

  logic [NBANK-1:0] open_v, lock_v, busy_v;
  logic [NBANK-1:0] act_v, rw_v, pre_v;
  logic             all_idle, any_lock, open_sel, busy_sel;

  sdr_cmd_decode u_dec (
    .cke_prev_i (cke_q),
    .cke_i      (cke),
    .cs_n_i     (cs_n),
    .ras_n_i    (ras_n),
    .cas_n_i    (cas_n),
    .we_n_i     (we_n),
    .ba_i       (ba),
    .cmd_o      (cmd)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit      = (ba == 1'(b));
    assign act_v[b] = accept && (cmd == C_ACT) && hit;
    assign rw_v[b]  = accept && ((cmd == C_RD) || (cmd == C_WR)) && hit;
    assign pre_v[b] = accept && (cmd == C_PRE) && (a10 || hit);

    sdr_bank_track #(.BL(BL), .TRP(TRP)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .act_i  (act_v[b]),
      .rw_i   (rw_v[b]),
      .ap_i   (a10),
      .pre_i  (pre_v[b]),
      .open_o (open_v[b]),
      .lock_o (lock_v[b]),
      .busy_o (busy_v[b])
    );
  end

  assign all_idle = ~|(open_v | busy_v);
  assign any_lock = |lock_v;
  assign open_sel = open_v[ba];
  assign busy_sel = busy_v[ba];

  always_comb begin
    err_next = E_NONE;
    if ((mrs_cnt_q != '0) && (cmd != C_DESEL) && (cmd != C_NOP)) begin
      err_next = E_SETTLE;
    end else begin
      unique case (cmd)
        C_MRS, C_EMRS: if (!all_idle) err_next = E_MRS_BUSY;
        C_AREF, C_SREF: if (!all_idle) err_next = E_REF_BUSY;
        C_RD, C_WR: begin
          if (any_lock)       err_next = E_AP_LOCK;
          else if (!open_sel) err_next = E_NO_ROW;
        end
        C_ACT: begin
          if (busy_sel)      err_next = E_ACT_EARLY;
          else if (open_sel) err_next = E_ROW_OPEN;
        end
        default: err_next = E_NONE;
      endcase
    end
  end

  assign accept = (err_next == E_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q     <= 1'b0;
      mrs_cnt_q <= '0;
      err_q     <= 4'd0;
      viol      <= 1'b0;
    end else begin
      cke_q <= cke;
      err_q <= err_next;
      viol  <= !accept;
      if (accept && ((cmd == C_MRS) || (cmd == C_EMRS)))
        mrs_cnt_q <= MW'(TMRD - 1);
      else if (mrs_cnt_q != '0)
        mrs_cnt_q <= mrs_cnt_q - 1'b1;
    end
  end

  assign err_code = err_q;

  // R11: the flag and the code always agree
  p_flag_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    viol == (err_code != 4'd0));

  // R4: inside the settling window a real command is flagged as such
  p_settle_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mrs_cnt_q != '0) && (cmd != C_DESEL) && (cmd != C_NOP))
      |=> (err_code == 4'd1));

  // R5: refresh with a bank in use is flagged
  p_ref_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mrs_cnt_q == '0) && ((cmd == C_AREF) || (cmd == C_SREF)) && !all_idle)
      |=> (err_code == 4'd3));

  // R7: read or write inside an auto-precharge burst is flagged
  p_ap_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mrs_cnt_q == '0) && ((cmd == C_RD) || (cmd == C_WR)) && any_lock)
      |=> (err_code == 4'd4));

  // R1: a deselected or clock-gated cycle never flags
  p_desel_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_DESEL) |=> (err_code == 4'd0));

endmodule

// File: tb/sdr_cmd_guard_tb.sv
module sdr_cmd_guard_tb;

  localparam int BL  = 4;
  localparam int TRP = 2;

  localparam logic [2:0] K_MRS = 3'b000, K_REF = 3'b001, K_PRE = 3'b010,
                         K_ACT = 3'b011, K_WR  = 3'b100, K_RD  = 3'b101,
                         K_BST = 3'b110, K_NOP = 3'b111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic ba = 1'b0, a10 = 1'b0;
  logic viol;
  logic [3:0] err_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdr_cmd_guard #(.BL(BL), .TRP(TRP), .TMRD(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
    .viol(viol), .err_code(err_code)
  );

  task automatic check(input logic [3:0] exp, input string tag);
    checks++;
    if (err_code !== exp || viol !== (exp != 4'd0)) begin
      errors++;
      $display("FAIL %s: err_code=%0d viol=%0b expected code=%0d viol=%0b",
               tag, err_code, viol, exp, exp != 4'd0);
    end
  endtask

  // drive at a falling edge, check the registered code one cycle later
  task automatic send(input logic k_cke, input logic k_cs, input logic [2:0] rcw,
                      input logic k_ba, input logic k_a10,
                      input logic [3:0] exp, input string tag);
    cke = k_cke; cs_n = k_cs; {ras_n, cas_n, we_n} = rcw; ba = k_ba; a10 = k_a10;
    @(negedge clk);
    check(exp, tag);
  endtask

  task automatic op(input logic [2:0] rcw, input logic k_ba, input logic k_a10,
                    input logic [3:0] exp, input string tag);
    send(1'b1, 1'b0, rcw, k_ba, k_a10, exp, tag);
  endtask

  task automatic t_reset;
    check(4'd0, "R1 reset");
    rst_n = 1'b1;
    send(1'b1, 1'b1, K_NOP, 0, 0, 4'd0, "R1 first cycle");
    op(K_BST, 0, 0, 4'd0, "R10 burst stop idle");
  endtask

  task automatic t_deselect;
    send(1'b1, 1'b1, K_RD, 0, 0, 4'd0, "R1 cs high ignored");
    send(1'b0, 1'b0, K_NOP, 0, 0, 4'd0, "R1 cke low nop");
    send(1'b1, 1'b0, K_RD, 1, 0, 4'd0, "R1 prev cke low ignored");
    op(K_NOP, 0, 0, 4'd0, "R1 nop");
  endtask

  task automatic t_mode;
    op(K_MRS, 0, 0, 4'd0, "R3 mrs idle");
    op(K_RD, 0, 0, 4'd1, "R12 settle beats no-row");
    op(K_BST, 0, 0, 4'd0, "R4 window over");
    op(K_MRS, 1, 0, 4'd0, "R2 emrs idle");
    op(K_NOP, 0, 0, 4'd0, "R4 nop in window");
    op(K_ACT, 0, 0, 4'd0, "R4 act after window");
    op(K_MRS, 0, 0, 4'd2, "R3 mrs with open row");
    op(K_BST, 0, 0, 4'd0, "R11 rejected mrs starts no window");
    op(K_REF, 0, 0, 4'd3, "R5 auto refresh busy");
    send(1'b0, 1'b0, K_REF, 0, 0, 4'd3, "R5 self refresh busy");
    op(K_NOP, 0, 0, 4'd0, "R1 nop");
    op(K_PRE, 1, 1, 4'd0, "R9 precharge all");
    op(K_REF, 0, 0, 4'd0, "R5 auto refresh idle");
    send(1'b0, 1'b0, K_REF, 0, 0, 4'd0, "R5 self refresh idle");
    send(1'b1, 1'b0, K_ACT, 0, 0, 4'd0, "R1 undecoded after cke low");
    op(K_RD, 0, 0, 4'd5, "R11 undecoded act opened nothing");
  endtask

  task automatic t_rows;
    op(K_RD, 1, 0, 4'd5, "R6 read closed bank");
    op(K_ACT, 1, 0, 4'd0, "R6 act bank1");
    op(K_ACT, 1, 0, 4'd6, "R6 act open bank");
    op(K_WR, 1, 0, 4'd0, "R6 write open bank");
    op(K_PRE, 0, 0, 4'd0, "R9 precharge bank0 only");
    op(K_RD, 1, 0, 4'd0, "R9 bank1 still open");
    op(K_PRE, 1, 0, 4'd0, "R9 precharge bank1");
    op(K_RD, 1, 0, 4'd5, "R9 bank1 closed");
    op(K_ACT, 0, 0, 4'd0, "R2 act bank0");
    op(K_ACT, 1, 0, 4'd0, "R2 act bank1");
    op(K_PRE, 0, 1, 4'd0, "R9 a10 closes both");
    op(K_WR, 1, 0, 4'd5, "R9 bank1 closed by a10");
    op(K_WR, 0, 0, 4'd5, "R9 bank0 closed by a10");
  endtask

  task automatic t_autopre;
    op(K_ACT, 0, 0, 4'd0, "R7 act bank0");
    op(K_ACT, 1, 0, 4'd0, "R7 act bank1");
    op(K_RD, 0, 1, 4'd0, "R7 read auto-precharge");        // offset 0
    op(K_WR, 1, 0, 4'd4, "R7 write other bank offset1");   // 1
    op(K_ACT, 0, 0, 4'd7, "R12 act during burst offset2"); // 2
    op(K_RD, 1, 0, 4'd4, "R7 read offset3");               // 3
    op(K_RD, 1, 0, 4'd0, "R7 read other bank offset BL");  // 4
    op(K_ACT, 0, 0, 4'd7, "R8 act before recovery");       // 5
    op(K_ACT, 0, 0, 4'd0, "R8 act at BL+TRP");             // 6
    op(K_PRE, 0, 1, 4'd0, "R9 close all");
    op(K_ACT, 1, 0, 4'd0, "R10 act bank1");
    op(K_WR, 1, 1, 4'd0, "R10 write auto-precharge");
    op(K_BST, 0, 0, 4'd0, "R10 burst stop in burst");
    op(K_RD, 1, 0, 4'd4, "R12 lock beats no-row");
    op(K_MRS, 0, 0, 4'd2, "R3 mrs during recovery");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_deselect();
    t_mode();
    t_rows();
    t_autopre();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule